// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits on the physical address path and classifies each access that falls in the legacy window from 0xA0000 to 0xFFFFF. Each access goes to one of three places: system DRAM with full read/write, DRAM with writes suppressed, or the expansion bus. Addresses outside the window always go to DRAM. The classification is purely combinational from the access address, the write flag, the SMM-active input and a small bank of byte-wide configuration registers. A new register value steers the very next access.

The window has three kinds of region. The top 64 KB (0xF0000..0xFFFFF) has its own 2-bit attribute code. The 192 KB below it (0xC0000..0xEFFFF) is split into twelve 16 KB segments, each with its own 2-bit code; two segments share one configuration byte. The 128 KB video hole (0xA0000..0xBFFFF) is decided by the SMRAM control byte together with the SMM-active input.

Top module: `lmr_window_decoder`

## Requirements
- R1: After synchronous reset, the attribute registers at offsets 0x59..0x5F read 0x00 and the SMRAM register at offset 0x72 reads 0x02. As a result, every address from 0xC0000 to 0xFFFFF is forwarded to the bus.
- R2: A configuration write at offset 0x59..0x5F or 0x72 stores the full byte, and a read at that offset returns it. Writes to any other offset change nothing, and reads of other offsets return 0x00.
- R3: The attribute code for 0xF0000..0xFFFFF is bits [5:4] of the register at offset 0x59.
- R4: Segment i (0..11) covers 0xC0000 + i*0x4000 up to 0x3FFF above that. Its code comes from the register at offset 0x5A + (i >> 1): bits [1:0] for an even i and bits [5:4] for an odd i.
- R5: Code 3 asserts dram_sel for reads and writes, with wr_drop low.
- R6: Code 1 asserts dram_sel. A write to such a region also asserts wr_drop; a read does not.
- R7: Codes 0 and 2 assert bus_fwd and leave dram_sel low.
- R8: An address in 0xA0000..0xBFFFF asserts dram_sel when SMRAM bit 6 is set, or when SMRAM bit 3 is set and smm_active is high. Otherwise it asserts bus_fwd.
- R9: Any address below 0xA0000 or at or above 0x100000 asserts dram_sel with wr_drop low, whatever the registers hold.
- R10: Exactly one of dram_sel and bus_fwd is high at all times. wr_drop is high only together with dram_sel and acc_write.
- R11: A register write is reflected in the routing from the next cycle on. A change of smm_active is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| smm_active | input | 1 | System management mode is active |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | Access is a write |
| dram_sel | output | 1 | Route the access to DRAM |
| bus_fwd | output | 1 | Forward the access to the expansion bus |
| wr_drop | output | 1 | Write hits a read-only region and is discarded |

## Verification
The bench builds the block with its defaults: a 32-bit address, twelve segments and a 14-bit segment shift. The wide address lets it place accesses just above 1 MB, where the low 20 bits alias into the window, and confirm that those accesses still go to DRAM. The shift gives 16 KB segments, so it can hit the last byte of one segment and the first byte of the next. That catches both nibble selection and byte-index errors. Random register contents and random in-window addresses are mixed with directed cases on the video hole under every SMRAM/SMM combination.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    localparam logic [7:0]  OFF_FSEG   = 8'h59;
    localparam logic [7:0]  OFF_SMRAM  = 8'h72;
    localparam logic [7:0]  SMRAM_RST  = 8'h02;
    localparam int unsigned SMR_OPEN_BIT = 6;
    localparam int unsigned SMR_SMM_BIT  = 3;

    localparam logic [19:0] VID_BASE  = 20'hA0000;
    localparam logic [19:0] OPT_BASE  = 20'hC0000;
    localparam logic [19:0] FSEG_BASE = 20'hF0000;

    typedef enum logic [1:0] {
        RGN_OUT   = 2'd0,
        RGN_VIDEO = 2'd1,
        RGN_SEG   = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        RT_BUS     = 2'd0,
        RT_DRAM_RO = 2'd1,
        RT_DRAM_RW = 2'd2
    } route_e;

    typedef struct packed {
        logic dram_sel;
        logic bus_fwd;
        logic wr_drop;
    } verdict_t;

    function automatic route_e code_to_route(input logic [1:0] code);
        case (code)
            2'd3:    return RT_DRAM_RW;
            2'd1:    return RT_DRAM_RO;
            default: return RT_BUS;
        endcase
    endfunction

endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
    import lmr_pkg::*;
#(
    parameter int unsigned PAM_N = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [PAM_N-1:0][7:0] pam_q,
    output logic [7:0]            smram_q
);
    localparam int unsigned IW      = (PAM_N > 1) ? $clog2(PAM_N) : 1;
    localparam logic [7:0]  PAM_END = OFF_FSEG + 8'(PAM_N);

    logic [7:0]    rel;
    logic [IW-1:0] idx;
    logic          hit_pam;
    logic          hit_smr;

    assign rel     = addr - OFF_FSEG;
    assign idx     = rel[IW-1:0];
    assign hit_pam = (addr >= OFF_FSEG) && (addr < PAM_END);
    assign hit_smr = (addr == OFF_SMRAM);

    always_ff @(posedge clk) begin
        if (rst) begin
            pam_q   <= '0;
            smram_q <= SMRAM_RST;
        end else if (we) begin
            if (hit_pam) pam_q[idx] <= wdata;
            if (hit_smr) smram_q    <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (hit_pam)      rdata = pam_q[idx];
        else if (hit_smr) rdata = smram_q;
    end

    // R1: reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (smram_q == SMRAM_RST && pam_q == '0));

    // R2: writes elsewhere leave the bank untouched
    p_ignore_other_r2: assert property (@(posedge clk) disable iff (rst)
        !(we && (hit_pam || hit_smr)) |=> ($stable(pam_q) && $stable(smram_q)));

endmodule

// File: rtl/lmr_seg_lookup.sv
module lmr_seg_lookup
    import lmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_SEG   = 12,
    parameter int unsigned SEG_SHIFT = 14,
    parameter int unsigned PAM_N     = 1 + (NUM_SEG + 1) / 2
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [PAM_N-1:0][7:0] pam_q,
    output region_e               region,
    output logic [1:0]            code
);
    localparam int unsigned SW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

    logic [1:0]  seg_code [NUM_SEG];
    logic        hi_zero;
    logic [19:0] low;
    logic [19:0] off;
    logic [19:0] off_sh;
    logic [SW-1:0] sidx;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        if (g % 2 == 0) begin : g_even
            assign seg_code[g] = pam_q[1 + g/2][1:0];
        end else begin : g_odd
            assign seg_code[g] = pam_q[1 + g/2][5:4];
        end
    end

    assign hi_zero = (addr[ADDR_W-1:20] == '0);
    assign low     = addr[19:0];
    assign off     = low - OPT_BASE;
    assign off_sh  = off >> SEG_SHIFT;
    assign sidx    = off_sh[SW-1:0];

    always_comb begin
        region = RGN_OUT;
        code   = 2'd0;
        if (hi_zero && low >= VID_BASE) begin
            if (low < OPT_BASE) begin
                region = RGN_VIDEO;
            end else if (low >= FSEG_BASE) begin
                region = RGN_SEG;
                code   = pam_q[0][5:4];
            end else begin
                region = RGN_SEG;
                code   = seg_code[sidx];
            end
        end
    end

endmodule

// File: rtl/lmr_window_decoder.sv
module lmr_window_decoder
    import lmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_SEG   = 12,
    parameter int unsigned SEG_SHIFT = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smm_active,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              dram_sel,
    output logic              bus_fwd,
    output logic              wr_drop
);
    localparam int unsigned PAM_N = 1 + (NUM_SEG + 1) / 2;

    logic [PAM_N-1:0][7:0] pam_q;
    logic [7:0]            smram_q;
    region_e               region;
    logic [1:0]            code;
    route_e                route;
    verdict_t              vd;
    logic                  vid_open;

    lmr_cfg_regs #(.PAM_N(PAM_N)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .pam_q   (pam_q),
        .smram_q (smram_q)
    );

    lmr_seg_lookup #(
        .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG),
        .SEG_SHIFT(SEG_SHIFT), .PAM_N(PAM_N)
    ) u_lookup (
        .addr   (acc_addr),
        .pam_q  (pam_q),
        .region (region),
        .code   (code)
    );

    assign vid_open = smram_q[SMR_OPEN_BIT] || (smm_active && smram_q[SMR_SMM_BIT]);
    assign route    = code_to_route(code);

    always_comb begin
        vd = '{dram_sel: 1'b1, bus_fwd: 1'b0, wr_drop: 1'b0};
        case (region)
            RGN_VIDEO: begin
                vd.dram_sel = vid_open;
                vd.bus_fwd  = !vid_open;
            end
            RGN_SEG: begin
                vd.dram_sel = (route != RT_BUS);
                vd.bus_fwd  = (route == RT_BUS);
                vd.wr_drop  = (route == RT_DRAM_RO) && acc_write;
            end
            default: ;
        endcase
    end

    assign dram_sel = vd.dram_sel;
    assign bus_fwd  = vd.bus_fwd;
    assign wr_drop  = vd.wr_drop;

    // R10: one destination only
    p_one_dest_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({dram_sel, bus_fwd}) == 1);

    // R10: drop only on a DRAM write
    p_drop_qual_r10: assert property (@(posedge clk) disable iff (rst)
        wr_drop |-> (dram_sel && acc_write));

    // R9: outside the window always DRAM
    p_outside_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_addr >= ADDR_W'(32'h100000) || acc_addr < ADDR_W'(32'hA0000))
        |-> (dram_sel && !wr_drop));

    // R11: forcing the video hole open applies from the next cycle
    p_open_next_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == OFF_SMRAM && cfg_wdata[SMR_OPEN_BIT])
        |=> (region != RGN_VIDEO || dram_sel));

endmodule

// File: tb/lmr_window_decoder_test.sv
module lmr_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        smm_active;
    logic [31:0] acc_addr;
    logic        acc_write;
    logic        dram_sel, bus_fwd, wr_drop;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    logic [7:0] pm [7];
    logic [7:0] sm;

    always #10 clk = ~clk;

    lmr_window_decoder uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_active(smm_active),
        .acc_addr(acc_addr), .acc_write(acc_write),
        .dram_sel(dram_sel), .bus_fwd(bus_fwd), .wr_drop(wr_drop)
    );

    function automatic logic [2:0] expv(logic [31:0] a, logic w, logic s);
        logic [1:0] c;
        int i;
        if (a >= 32'h100000 || a < 32'hA0000) return 3'b100;
        if (a < 32'hC0000) return ((s && sm[3]) || sm[6]) ? 3'b100 : 3'b010;
        if (a >= 32'hF0000) c = pm[0][5:4];
        else begin
            i = int'((a - 32'hC0000) >> 14);
            c = (i % 2 == 1) ? pm[1 + i/2][5:4] : pm[1 + i/2][1:0];
        end
        case (c)
            2'd3:    return 3'b100;
            2'd1:    return {2'b10, w};
            default: return 3'b010;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] o);
        if (o >= 8'h59 && o <= 8'h5F) return pm[o - 8'h59];
        if (o == 8'h72) return sm;
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_wr(logic [7:0] o, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = o; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (o >= 8'h59 && o <= 8'h5F) pm[o - 8'h59] = d;
        if (o == 8'h72) sm = d;
    endtask

    task automatic acc(string req, logic [31:0] a, logic w, logic s);
        acc_addr = a; acc_write = w; smm_active = s;
        #2;
        chk(req, {29'd0, dram_sel, bus_fwd, wr_drop}, {29'd0, expv(a, w, s)});
    endtask

    task automatic rd(string req, logic [7:0] o);
        cfg_addr = o;
        #2;
        chk(req, {24'd0, cfg_rdata}, {24'd0, exp_rd(o)});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        smm_active = 0; acc_addr = 0; acc_write = 0;
        for (int k = 0; k < 7; k++) pm[k] = 8'h00;
        sm = 8'h02;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int k = 8'h59; k <= 8'h5F; k++) rd("R1 pam reset", 8'(k));
        rd("R1 smram reset", 8'h72);
        acc("R1 fseg fwd", 32'hF8000, 0, 0);
        acc("R1 cseg fwd", 32'hC0000, 1, 1);
        acc("R8 video closed", 32'hA0000, 0, 1);

        // R2 unmapped offsets
        cfg_wr(8'h58, 8'hFF);
        rd("R2 unmapped 58", 8'h58);
        cfg_wr(8'h73, 8'hFF);
        rd("R2 unmapped 73", 8'h73);
        acc("R2 no effect", 32'hB0000, 0, 1);

        // R8 / R11 video hole
        cfg_wr(8'h72, 8'h08);
        acc("R8 smm off", 32'hA1234, 0, 0);
        acc("R11 smm on", 32'hA1234, 0, 1);
        acc("R11 smm off again", 32'hBFFFF, 1, 0);
        cfg_wr(8'h72, 8'h40);
        acc("R8 forced open", 32'hBFFFF, 1, 0);
        rd("R2 smram rd", 8'h72);

        // R3 / R5 / R6 / R7 top segment
        cfg_wr(8'h59, 8'h30);
        acc("R5 fseg rw", 32'hFFFFF, 1, 0);
        cfg_wr(8'h59, 8'h10);
        acc("R6 fseg ro write", 32'hF0000, 1, 0);
        acc("R6 fseg ro read", 32'hF0000, 0, 0);
        cfg_wr(8'h59, 8'h23);
        acc("R7 fseg code2", 32'hF4000, 1, 0);

        // R4 segment boundaries
        cfg_wr(8'h5A, 8'h31);
        acc("R4 seg0 last", 32'hC3FFF, 1, 0);
        acc("R4 seg1 first", 32'hC4000, 1, 0);
        cfg_wr(8'h5F, 8'h10);
        acc("R4 seg11 last", 32'hEFFFF, 1, 0);
        acc("R4 seg10", 32'hE8000, 1, 0);

        // R9 outside window and alias above 1 MB
        acc("R9 below", 32'h9FFFF, 1, 0);
        acc("R9 alias", 32'h1F0000, 1, 0);
        acc("R9 alias video", 32'hFFFA0000, 0, 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                int sel;
                logic [7:0] o;
                sel = $urandom_range(0, 8);
                o = (sel == 8) ? 8'h72 : (sel == 7) ? 8'($urandom_range(0, 255)) : 8'(8'h59 + sel);
                cfg_wr(o, 8'($urandom));
                rd("R2 random rd", o);
            end
            @(negedge clk);
            begin
                logic [31:0] a;
                a = ($urandom_range(0, 7) == 0) ? $urandom : 32'hA0000 + $urandom_range(0, 32'h5FFFF);
                acc("R10 random", a, 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule